// File: doc/BRIEF.md
# Write-Locked Watchdog Timer

This block is a retriggerable watchdog. It sends a one-cycle reset pulse to the rest of the chip when its counter has counted a programmable number of ticks without being serviced. A small configuration register selects four things: the terminal count, whether counting goes on while the chip is halted, whether it goes on while the chip is stopped, and which tick source drives the counter. The tick source is either every system clock or a clock-enable strobe that stands in for a slow internal oscillator.

Software can write the configuration only during a short window right after reset. After that window the register is frozen until the next reset. The watchdog does nothing until the first kick strobe. That strobe arms it, and every later kick restarts the count from zero. When the pulse fires, the counter clears and the watchdog goes back to idle until it is kicked again.

Top module: `wdt_guard`

## Requirements
- R1: With bit 4 of the configuration byte set to 1 (system-clock ticks), the tap field in bits [1:0] sets the number of ticks from a kick to the pulse: 00 gives 128, 01 gives 256, 10 gives 512 and 11 gives 2048.
- R2: After reset and with no write, the configuration is tap 01, counting enabled in halt and in stop, and the slow tick source selected. With `slow_tick` held high, the pulse therefore comes 256 cycles after a kick, even while `halt` and `stop` are both high.
- R3: With bit 4 equal to 0, the counter advances only on cycles where `slow_tick` is high. With `slow_tick` low the count never reaches its terminal value.
- R4: A write is accepted on the first 64 rising clock edges after reset is released, that is edge indices 0 to 63. A write on edge 64 or later has no effect.
- R5: Bits [7:5] of the written byte are reserved and have no effect on the watchdog's behaviour.
- R6: After reset the watchdog stays idle and issues no pulse until the first kick, however long it waits.
- R7: A kick while the watchdog is armed clears the count, so the next pulse comes one full period after the last kick.
- R8: When `halt` is high and bit 2 (halt enable) is 0, the count holds its value. When bit 2 is 1, counting goes on during halt.
- R9: When `stop` is high and bit 3 (stop enable) is 0, the count holds its value. When bit 3 is 1, counting goes on during stop.
- R10: `wdt_rst` is high for exactly one cycle. The pulse appears in the cycle after the edge on which the terminal tick is counted. After the pulse the watchdog is idle again and issues no further pulse until it is kicked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration byte: [1:0] tap, [2] halt enable, [3] stop enable, [4] tick select, [7:5] reserved |
| slow_tick | input | 1 | Clock-enable from the slow internal oscillator |
| halt | input | 1 | Chip is in the halt low-power state |
| stop | input | 1 | Chip is in the stop low-power state |
| kick | input | 1 | Service strobe: arms the watchdog and restarts the count |
| wdt_rst | output | 1 | One-cycle reset request to the system |

## Verification
The period is measured from a kick to the pulse for every tap code, on both tick sources, and with bytes that have the reserved bits set. These runs separate a wrong tap decode from a wrong source selection or from leakage through the reserved bits. Writes are placed on edge 63 and on edge 64 after reset, which separates a window that is off by one from a correct one. Halt and stop are each raised with their enable bit cleared and with it set, which shows whether each gate is tied to its own enable bit. Idle waits, retrigger kicks and the cycle after each pulse show whether the arm and disarm sequencing is correct.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  localparam int unsigned CFG_BYTE_W = 8;

  typedef struct packed {
    logic       clk_sel;  // 1: every system clock ticks, 0: slow_tick enables
    logic       stop_en;  // count while stop is high
    logic       halt_en;  // count while halt is high
    logic [1:0] tap;      // terminal count select
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RESET = '{clk_sel: 1'b0, stop_en: 1'b1,
                                     halt_en: 1'b1, tap: 2'b01};

  // Reserved bits [7:5] are dropped here.
  function automatic wdt_cfg_t unpack_cfg(input logic [CFG_BYTE_W-1:0] b);
    wdt_cfg_t c;
    c.clk_sel = b[4];
    c.stop_en = b[3];
    c.halt_en = b[2];
    c.tap     = b[1:0];
    return c;
  endfunction

  function automatic int unsigned tap_limit(input logic [1:0] tap,
                                            input int unsigned l0,
                                            input int unsigned l1,
                                            input int unsigned l2,
                                            input int unsigned l3);
    case (tap)
      2'b00:   return l0;
      2'b01:   return l1;
      2'b10:   return l2;
      default: return l3;
    endcase
  endfunction

endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_guard_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CFG_BYTE_W-1:0] wr_data,
  output wdt_cfg_t              cfg_q,
  output logic                  win_open
);
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             wr_accept;

  assign win_open  = (win_cnt < WIN_W'(WIN_CYCLES));
  assign wr_accept = wr_en && win_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      cfg_q   <= CFG_RESET;
    end else begin
      if (win_open) win_cnt <= win_cnt + 1'b1;
      if (wr_accept) cfg_q <= unpack_cfg(wr_data);
    end
  end

  // R4: once the window has closed the register never changes
  a_r4_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(cfg_q));
  // R4: the window never reopens without a reset
  a_r4_window_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> !win_open);

endmodule

// File: rtl/wdt_tick_gate.sv
module wdt_tick_gate
  import wdt_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_cfg_t cfg,
  input  logic     slow_tick,
  input  logic     halt,
  input  logic     stop,
  output logic     tick
);
  logic src_tick;
  logic halt_block;
  logic stop_block;

  assign src_tick   = cfg.clk_sel ? 1'b1 : slow_tick;
  assign halt_block = halt && !cfg.halt_en;
  assign stop_block = stop && !cfg.stop_en;
  assign tick       = src_tick && !halt_block && !stop_block;

  // R8: halt with counting disabled blocks every tick
  a_r8_halt_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cfg.halt_en) |-> !tick);
  // R9: stop with counting disabled blocks every tick
  a_r9_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cfg.stop_en) |-> !tick);
  // R3: slow source selected and no strobe means no tick
  a_r3_slow_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.clk_sel && !slow_tick) |-> !tick);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] last_val,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             fire_q
);
  logic hit;

  assign hit = armed && tick && (cnt == last_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      cnt    <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (kick) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (hit) begin
        armed  <= 1'b0;
        cnt    <= '0;
        fire_q <= 1'b1;
      end else if (armed && tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
  // R10: the pulse leaves the watchdog disarmed unless it was kicked
  a_r10_idle_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !$past(kick)) |-> (!armed && cnt == '0));
  // R7: a kick restarts the count and arms
  a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (armed && cnt == '0));
  // R6: idle without kick does not count
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !kick) |=> (cnt == '0 && !armed));
  // R8 R9: no tick, no kick: count holds
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !kick) |=> $stable(cnt));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 64,
  parameter int unsigned LIM0       = 128,
  parameter int unsigned LIM1       = 256,
  parameter int unsigned LIM2       = 512,
  parameter int unsigned LIM3       = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_wr_data,
  input  logic       slow_tick,
  input  logic       halt,
  input  logic       stop,
  input  logic       kick,
  output logic       wdt_rst
);
  localparam int unsigned CNT_W = $clog2(LIM3 + 1);

  wdt_cfg_t         cfg_q;
  logic             win_open;
  logic             tick;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_val;

  assign last_val = CNT_W'(tap_limit(cfg_q.tap, LIM0, LIM1, LIM2, LIM3) - 1);

  wdt_cfg_lock #(.WIN_CYCLES(WIN_CYCLES)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .cfg_q    (cfg_q),
    .win_open (win_open)
  );

  wdt_tick_gate gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_q),
    .slow_tick (slow_tick),
    .halt      (halt),
    .stop      (stop),
    .tick      (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick),
    .tick     (tick),
    .last_val (last_val),
    .armed    (armed),
    .cnt      (cnt),
    .fire_q   (wdt_rst)
  );

  // R1: the count never passes the selected terminal value
  a_r1_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_val);
  // R4: a write accepted while the window is open shows up in the register
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && win_open) |=> (cfg_q.tap == $past(cfg_wr_data[1:0])));

endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  // Configuration byte, slow_tick level, expected period in cycles.
  localparam logic [7:0] VEC_CFG  [NVEC] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'hF0, 8'h02, 8'hE3};
  localparam logic       VEC_SLOW [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int         VEC_PER  [NVEC] = '{128, 256, 512, 2048, 128, 512, 2048};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic       slow_tick = 1'b0;
  logic       halt = 1'b0;
  logic       stop = 1'b0;
  logic       kick = 1'b0;
  logic       wdt_rst;

  int n_chk = 0;
  int n_bad = 0;
  int got;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .slow_tick(slow_tick), .halt(halt), .stop(stop), .kick(kick), .wdt_rst(wdt_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr_en = 1'b0; kick = 1'b0;
    halt = 1'b0; stop = 1'b0; slow_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [7:0] b);
    cfg_wr_en = 1'b1; cfg_wr_data = b;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Cycles until the pulse, 0 if none within lim.
  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (wdt_rst) begin n = i; break; end
    end
  endtask

  task automatic kick_measure(input int lim, output int n);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    wait_pulse(lim, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Reset state: no pulse during reset (R10)
    repeat (2) @(negedge clk);
    check("R10 reset output", int'(wdt_rst), 0);

    // Table: tap codes, tick sources, reserved bits (R1 R3 R5)
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      write_cfg(VEC_CFG[v]);
      slow_tick = VEC_SLOW[v];
      kick_measure(3000, got);
      check("R1 R3 R5 period", got, VEC_PER[v]);
      @(negedge clk);
      check("R10 pulse width", int'(wdt_rst), 0);
    end

    // R2 defaults: tap 01, slow source, halt and stop both counting
    do_reset();
    slow_tick = 1'b1; halt = 1'b1; stop = 1'b1;
    kick_measure(3000, got);
    check("R2 default period", got, 256);

    // R3: slow source with no strobe never expires
    do_reset();
    write_cfg(8'h00);
    kick_measure(400, got);
    check("R3 slow stalled", got, 0);
    slow_tick = 1'b1;
    wait_pulse(400, got);
    check("R3 slow resumes", got, 128);

    // R4: last edge inside the window accepts
    do_reset();
    repeat (63) @(negedge clk);
    write_cfg(8'h10);
    slow_tick = 1'b1;
    kick_measure(3000, got);
    check("R4 write at edge 63", got, 128);

    // R4: first edge past the window ignores the write
    do_reset();
    repeat (64) @(negedge clk);
    write_cfg(8'h10);
    slow_tick = 1'b1;
    kick_measure(3000, got);
    check("R4 write at edge 64", got, 256);

    // R6 idle until kicked; R7 retrigger; R10 back to idle
    do_reset();
    write_cfg(8'h10);
    wait_pulse(500, got);
    check("R6 idle no pulse", got, 0);
    kick_measure(100, got);
    check("R7 no pulse before retrigger", got, 0);
    kick_measure(300, got);
    check("R7 period after retrigger", got, 128);
    wait_pulse(600, got);
    check("R10 idle after pulse", got, 0);

    // R8: halt with enable clear holds; enable set counts
    do_reset();
    write_cfg(8'h18);
    halt = 1'b1;
    kick_measure(300, got);
    check("R8 halt holds", got, 0);
    halt = 1'b0;
    wait_pulse(300, got);
    check("R8 resume after halt", got, 128);
    do_reset();
    write_cfg(8'h14);
    halt = 1'b1;
    kick_measure(300, got);
    check("R8 halt enabled counts", got, 128);

    // R9: stop with enable clear holds; enable set counts
    do_reset();
    write_cfg(8'h14);
    stop = 1'b1;
    kick_measure(300, got);
    check("R9 stop holds", got, 0);
    stop = 1'b0;
    wait_pulse(300, got);
    check("R9 resume after stop", got, 128);
    do_reset();
    write_cfg(8'h18);
    stop = 1'b1;
    kick_measure(300, got);
    check("R9 stop enabled counts", got, 128);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule